// File: doc/BRIEF.md
# Status Byte Transfer Controller

This block carries status bytes from a local sub-CPU to a host port. The sub-CPU pushes bytes into a 12-entry status queue. Each accepted push starts a status transfer. The block then presents the oldest byte to the host behind an active-low ready strobe. The host takes a byte by pulsing its read line while the strobe is low. The strobe then rises for one cycle, and it falls again if more bytes are queued. A busy flag that the sub-CPU can read drops when a transfer starts and rises again when the host has taken the last queued byte.

A two-bit control word sets how the block behaves:
- **Enable bit.** This bit turns status output on. Clearing it flushes the queue and aborts any transfer in progress.
- **Interlock bit.** When the interlock is active, the strobe is held back until the data path reports through its end indication that its own transfer has finished.
- **Reset.** Reset clears both bits. So after reset, output is off and the interlock is active.

Top module: `stat_xfer_ctrl`

## Requirements
- R1: After reset, `stat_rdy_n` is 1, `stat_busy` is 1 and `stat_ovf` is 0. Both control bits read as 0, so status output is disabled and the WAIT interlock is active.
- R2: The control word is written with `ctrl_wr`. Bit 0 set to 1 enables status output. Bit 1 set to 0 activates the WAIT interlock, and set to 1 disables it. A `cpu_wr` while bit 0 is 0 is ignored: the strobe stays high and busy stays 1.
- R3: The queue holds 12 bytes and hands them out in write order. A `cpu_wr` while 12 bytes are held is ignored, and it sets `stat_ovf`. `stat_ovf` stays set until reset or until the enable bit is cleared.
- R4: An accepted `cpu_wr` drives `stat_busy` to 0 at the clock edge that stores the byte.
- R5: With the interlock disabled, `stat_rdy_n` goes low at the clock edge that stores the byte.
- R6: With the interlock active and `data_end` at 1, `stat_rdy_n` goes low at the clock edge that stores the byte, together with `stat_busy`.
- R7: With the interlock active and `data_end` at 0, `stat_rdy_n` stays high while bytes are queued. It goes low at the first clock edge that samples `data_end` at 1.
- R8: A `host_rd` while `stat_rdy_n` is low removes the head byte. The strobe is high for the next cycle, then goes low again if bytes remain and the interlock permits. A `host_rd` while `stat_rdy_n` is high removes nothing.
- R9: `stat_busy` returns to 1 at the edge where the host takes the last queued byte.
- R10: Writing the control word with bit 0 at 0 empties the queue at that edge. It also forces `stat_rdy_n` to 1 and `stat_busy` to 1, and clears `stat_ovf`.
- R11: While `stat_rdy_n` is low, `host_rdata` shows the oldest queued byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 2 | Control word: bit 0 enables output, bit 1 disables the interlock |
| cpu_wr | input | 1 | Sub-CPU status byte write strobe |
| cpu_wdata | input | 8 | Status byte from the sub-CPU |
| data_end | input | 1 | Data path end indication (1 = data transfer finished) |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Head status byte for the host |
| stat_rdy_n | output | 1 | Active-low status-ready strobe |
| stat_busy | output | 1 | Status busy flag, 0 while a transfer is pending |
| stat_ovf | output | 1 | Sticky queue overflow flag |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:
- a push gives a low strobe, busy at 0 and the new head byte;
- a host read gives a high strobe;
- a flush gives the cleared state;
- `data_end` rising gives the release of a held strobe.

The single exception is that the strobe falls again for the next byte one edge after the read edge. The bench drives each input just after a rising edge and samples 1 ns after the following edge. It then repeats single idle cycles to observe the one-cycle high gap and the held strobe under the interlock.

// File: rtl/stx_pkg.sv
// Package: shared types and control-word layout for the status transfer block.
// Assumes: a two-bit control word; bit positions are fixed here only.
package stx_pkg;

    localparam int CTRL_W          = 2;
    localparam int CTRL_EN_BIT     = 0;  // 1 = status output enabled
    localparam int CTRL_WAITDIS_BIT = 1; // 1 = WAIT interlock disabled

    typedef enum logic {
        STB_IDLE  = 1'b0,  // strobe high, nothing presented
        STB_READY = 1'b1   // strobe low, head byte presented
    } stb_state_e;

endpackage

// File: rtl/stx_fifo.sv
// Module: status byte queue.
// What: first-in first-out store of DEPTH entries with synchronous flush.
// Assumes: push when full and pop when empty are dropped here as a safeguard;
//          flush has priority over push and pop.
module stx_fifo #(
    parameter int DEPTH = 12,
    parameter int WIDTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             push_i;
    logic             pop_i;

    // Gate requests with occupancy.
    always_comb begin
        push_i = push && !full && !flush;
        pop_i  = pop && !empty && !flush;
    end

    // Step a pointer with wrap for non-power-of-two depths.
    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    // Per-entry storage written at the write pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_i && (wr_ptr == PW'(g))) mem[g] <= wdata;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= ptr_next(wr_ptr);
            if (pop_i)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Status decode and head output.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
        rdata = mem[rd_ptr];
    end

endmodule

// File: rtl/stx_ctrl.sv
// Module: control word register.
// What: holds the output enable and interlock disable bits; raises a flush
//       pulse in the cycle the enable bit is written as 0.
// Assumes: reset clears every bit.
module stx_ctrl
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              out_en,
    output logic              wait_dis,
    output logic              flush
);

    logic [CTRL_W-1:0] ctrl_q;

    // Register the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_wdata;
    end

    // Decode fields and the abort pulse.
    always_comb begin
        out_en   = ctrl_q[CTRL_EN_BIT];
        wait_dis = ctrl_q[CTRL_WAITDIS_BIT];
        flush    = ctrl_wr && !ctrl_wdata[CTRL_EN_BIT];
    end

endmodule

// File: rtl/stx_strobe_seq.sv
// Module: strobe and busy sequencer.
// What: presents the head byte by lowering the ready strobe when bytes are
//       queued and the interlock permits; releases it after each host read;
//       tracks the busy flag across the transfer.
// Assumes: push_ok and flush come from the top already qualified.
module stx_strobe_seq
    import stx_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          host_rd,
    input  logic          fifo_empty,
    input  logic [CW-1:0] fifo_count,
    input  logic          permit,
    output logic          pop_ok,
    output logic          rdy_n,
    output logic          busy
);

    stb_state_e state_q;
    stb_state_e state_d;
    logic       last_pop;

    // Qualify the host read and detect the final byte leaving.
    always_comb begin
        pop_ok   = host_rd && (state_q == STB_READY) && !flush;
        last_pop = pop_ok && (fifo_count == CW'(1)) && !push_ok;
    end

    // Next strobe state.
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = STB_IDLE;
        end else if (state_q == STB_READY) begin
            if (pop_ok) state_d = STB_IDLE;
        end else if ((!fifo_empty || push_ok) && permit) begin
            state_d = STB_READY;
        end
    end

    // Strobe state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STB_IDLE;
        else        state_q <= state_d;
    end

    // Busy flag: low from the first push until the last byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) busy <= 1'b1;
        else if (push_ok)    busy <= 1'b0;
        else if (last_pop)   busy <= 1'b1;
    end

    // Active-low strobe decode.
    always_comb rdy_n = (state_q != STB_READY);

endmodule

// File: rtl/stat_xfer_ctrl.sv
// Module: status byte transfer controller (top).
// What: sub-CPU writes queue status bytes; the host reads them behind an
//       active-low ready strobe gated by the data-path interlock.
// Assumes: one sub-CPU write and one host read per cycle at most.
module stat_xfer_ctrl
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 12,
    parameter int DATA_W     = 8,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              data_end,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              stat_rdy_n,
    output logic              stat_busy,
    output logic              stat_ovf
);

    logic          out_en;
    logic          wait_dis;
    logic          flush;
    logic          push_ok;
    logic          ovf_set;
    logic          pop_ok;
    logic          permit;
    logic          fifo_full;
    logic          fifo_empty;
    logic [CW-1:0] fifo_count;

    stx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .out_en     (out_en),
        .wait_dis   (wait_dis),
        .flush      (flush)
    );

    // Qualify sub-CPU writes and the interlock.
    always_comb begin
        push_ok = cpu_wr && out_en && !fifo_full && !flush;
        ovf_set = cpu_wr && out_en && fifo_full && !flush;
        permit  = wait_dis || data_end;
    end

    stx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (cpu_wdata),
        .rdata (host_rdata),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    stx_strobe_seq #(
        .CW (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_ok    (push_ok),
        .host_rd    (host_rd),
        .fifo_empty (fifo_empty),
        .fifo_count (fifo_count),
        .permit     (permit),
        .pop_ok     (pop_ok),
        .rdy_n      (stat_rdy_n),
        .busy       (stat_busy)
    );

    // Sticky overflow flag, cleared by reset or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) stat_ovf <= 1'b0;
        else if (ovf_set)    stat_ovf <= 1'b1;
    end

endmodule

// File: rtl/stx_checker.sv
// Module: protocol checker for the status transfer controller, bound to the top.
// What: temporal properties over ports and sub-block boundary signals.
module stx_checker #(
    parameter int DEPTH = 12,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr,
    input logic [1:0]    ctrl_wdata,
    input logic          cpu_wr,
    input logic          host_rd,
    input logic          data_end,
    input logic          wait_dis,
    input logic          stat_rdy_n,
    input logic          stat_busy,
    input logic          stat_ovf,
    input logic [CW-1:0] fifo_count
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && fifo_count == CW'(DEPTH) && !host_rd && !(ctrl_wr && !ctrl_wdata[0]))
        |=> (fifo_count == CW'(DEPTH)));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovf && !(ctrl_wr && !ctrl_wdata[0])) |=> stat_ovf);

    p_busy_when_queued_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count != '0) |-> !stat_busy);

    p_strobe_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rdy_n) |-> ($past(wait_dis) || $past(data_end)));

    p_gap_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdy_n && host_rd && !ctrl_wr) |=> stat_rdy_n);

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[0]) |=> (stat_rdy_n && stat_busy && !stat_ovf && fifo_count == '0));

    p_strobe_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rdy_n |-> (fifo_count != '0));

endmodule

bind stat_xfer_ctrl stx_checker #(
    .DEPTH (FIFO_DEPTH),
    .CW    (CW)
) u_stx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .cpu_wr     (cpu_wr),
    .host_rd    (host_rd),
    .data_end   (data_end),
    .wait_dis   (wait_dis),
    .stat_rdy_n (stat_rdy_n),
    .stat_busy  (stat_busy),
    .stat_ovf   (stat_ovf),
    .fifo_count (fifo_count)
);

// File: tb/stat_xfer_ctrl_bench.sv
module stat_xfer_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctrl_wr;
    logic [1:0] ctrl_wdata;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic       data_end;
    logic       host_rd;
    logic [7:0] host_rdata;
    logic       stat_rdy_n;
    logic       stat_busy;
    logic       stat_ovf;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    stat_xfer_ctrl u_stat_xfer_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .data_end   (data_end),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .stat_rdy_n (stat_rdy_n),
        .stat_busy  (stat_busy),
        .stat_ovf   (stat_ovf)
    );

    // Vector: [19:18] op (0 idle, 1 cpu write, 2 host read), [17:10] data,
    // [9] expected strobe, [8] expected busy, [7:0] expected head (when strobe low).
    localparam logic [19:0] VEC [8] = '{
        {2'd1, 8'hA1, 1'b0, 1'b0, 8'hA1},
        {2'd1, 8'hB2, 1'b0, 1'b0, 8'hA1},
        {2'd2, 8'h00, 1'b1, 1'b0, 8'h00},
        {2'd0, 8'h00, 1'b0, 1'b0, 8'hB2},
        {2'd2, 8'h00, 1'b1, 1'b1, 8'h00},
        {2'd0, 8'h00, 1'b1, 1'b1, 8'h00},
        {2'd1, 8'hC3, 1'b0, 1'b0, 8'hC3},
        {2'd2, 8'h00, 1'b1, 1'b1, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven; sample 1 ns after the edge, then idle inputs.
    task automatic tick();
        @(posedge clk);
        #1;
        ctrl_wr = 1'b0;
        cpu_wr  = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [1:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v; tick();
    endtask

    task automatic wr_cpu(input logic [7:0] d);
        cpu_wr = 1'b1; cpu_wdata = d; tick();
    endtask

    task automatic rd_host();
        host_rd = 1'b1; tick();
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = 2'b11; cpu_wr = 1'b0;
        cpu_wdata = 8'h00; data_end = 1'b0; host_rd = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdy_n", 8'(stat_rdy_n), 8'd1);
        chk("R1 busy",  8'(stat_busy),  8'd1);
        chk("R1 ovf",   8'(stat_ovf),   8'd0);

        // R2: writes ignored while output disabled (reset cleared the enable)
        data_end = 1'b1;
        wr_cpu(8'h5A);
        chk("R2 rdy_n ignored", 8'(stat_rdy_n), 8'd1);
        chk("R2 busy ignored",  8'(stat_busy),  8'd1);
        tick();
        chk("R2 rdy_n later", 8'(stat_rdy_n), 8'd1);

        // R5 R8 R9 R11: table walk with interlock disabled
        data_end = 1'b0;
        wr_ctrl(2'b11);
        for (int i = 0; i < 8; i++) begin
            case (VEC[i][19:18])
                2'd1:    wr_cpu(VEC[i][17:10]);
                2'd2:    rd_host();
                default: tick();
            endcase
            chk($sformatf("R5/R8 rdy_n vec%0d", i), 8'(stat_rdy_n), 8'(VEC[i][9]));
            chk($sformatf("R9 busy vec%0d", i),     8'(stat_busy),  8'(VEC[i][8]));
            if (!VEC[i][9]) chk($sformatf("R11 head vec%0d", i), host_rdata, VEC[i][7:0]);
        end

        // R7: interlock active, data_end low holds the strobe
        wr_ctrl(2'b01);
        data_end = 1'b0;
        wr_cpu(8'h55);
        chk("R4 busy low", 8'(stat_busy), 8'd0);
        chk("R7 held", 8'(stat_rdy_n), 8'd1);
        rd_host(); // R8: read while strobe high is ignored
        tick(); tick();
        chk("R7 still held", 8'(stat_rdy_n), 8'd1);
        data_end = 1'b1;
        tick();
        chk("R7 released", 8'(stat_rdy_n), 8'd0);
        chk("R8 ignored read kept head", host_rdata, 8'h55);
        rd_host();
        chk("R9 busy back", 8'(stat_busy), 8'd1);

        // R6: interlock active with data_end already high
        wr_cpu(8'h66);
        chk("R6 rdy_n", 8'(stat_rdy_n), 8'd0);
        chk("R6 busy",  8'(stat_busy),  8'd0);
        chk("R6 head",  host_rdata,     8'h66);
        rd_host();

        // R3: fill to 12, overflow write, order and sticky flag
        wr_ctrl(2'b11);
        for (int i = 0; i < 12; i++) wr_cpu(8'h10 + 8'(i));
        chk("R3 no ovf at 12", 8'(stat_ovf), 8'd0);
        wr_cpu(8'hEE);
        chk("R3 ovf set", 8'(stat_ovf), 8'd1);
        for (int i = 0; i < 12; i++) begin
            chk($sformatf("R3 order %0d", i), host_rdata, 8'h10 + 8'(i));
            rd_host();
            chk("R8 gap", 8'(stat_rdy_n), 8'd1);
            if (i < 11) tick();
        end
        chk("R9 busy after 12", 8'(stat_busy), 8'd1);
        tick();
        chk("R3 overflow byte dropped", 8'(stat_rdy_n), 8'd1);
        chk("R3 ovf sticky", 8'(stat_ovf), 8'd1);

        // R10: abort mid-transfer
        for (int i = 0; i < 3; i++) wr_cpu(8'h30 + 8'(i));
        chk("R10 pre rdy_n", 8'(stat_rdy_n), 8'd0);
        wr_ctrl(2'b10);
        chk("R10 rdy_n", 8'(stat_rdy_n), 8'd1);
        chk("R10 busy",  8'(stat_busy),  8'd1);
        chk("R10 ovf",   8'(stat_ovf),   8'd0);
        wr_ctrl(2'b11);
        wr_cpu(8'h99);
        chk("R10 emptied head", host_rdata, 8'h99);
        rd_host();
        chk("R10 single byte busy", 8'(stat_busy), 8'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule